// File: doc/BRIEF.md
# System-Management RAM Window Remap Decoder

This block compares each host memory address against one 64 KB window reserved for system-management code and, on a match, steers the access into a DRAM page. A single configuration byte sets the behaviour. One bit turns the window on. A second bit lets the window hit outside system-management mode as well. Two bits select one of four pairings of host page and DRAM page. One more bit drives a flag that lifts the address-line-20 mask while in system-management mode.

The configuration byte sits behind a simple synchronous write port and can always be read back. The address decode is combinational: the hit flag and the translated DRAM address follow the host address in the same cycle. The window state is captured only when a write changes one of the bits that steer the decode. Writes that touch only the other bits leave the decode untouched.

Top module: `smram_remap_decoder`

## Requirements
- R1: A write stores only bits 7, 5, 4, 3, 2 and 1 of the data (mask 0xBE). The readback shows the stored value on the cycle after the write, with bits 6 and 0 reading as zero.
- R2: While configuration bit 1 is clear, `hit` stays low for every address and every value of `smmActive`.
- R3: Bit 4 selects the host page: 0 selects 0x60000 and 1 selects 0xE0000. Bit 3 selects the DRAM page: 0 selects 0xA0000 and 1 selects 0xB0000. This gives the four pairings 00, 01, 10 and 11.
- R4: With bits 2 and 1 both set, the window hits whether or not `smmActive` is high. With bit 1 set and bit 2 clear, the window hits only while `smmActive` is high.
- R5: `a20Unmask` equals configuration bit 5.
- R6: On a hit, `dramAddr` is the selected DRAM page base plus `hostAddr[15:0]`, valid in the same cycle as `hit`. On a miss, `dramAddr` passes `hostAddr` through unchanged.
- R7: The window is exactly 64 KB. An address hits only if all of its bits above bit 15 equal the selected host page, so neighbouring pages and high-address aliases miss.
- R8: After reset the byte reads 0x00, `hit` is low and `a20Unmask` is low.
- R9: A write takes effect on the decode from the next cycle on. Writes that change only bits 7 or 0 have no effect on `hit`, `dramAddr` or `a20Unmask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 8 | Configuration write data |
| cfgRdata | output | 8 | Stored configuration byte |
| hostAddr | input | ADDR_W | Host memory address |
| smmActive | input | 1 | High while the CPU is in system-management mode |
| hit | output | 1 | Address falls in the active remap window |
| dramAddr | output | ADDR_W | Translated address, or the host address on a miss |
| a20Unmask | output | 1 | Lift the A20 mask while in system-management mode |

## Verification
The assertions check on every cycle that a disabled window never hits and that an SMM-only window never hits outside SMM. They also check that any hit falls in one of the two legal host pages, that a hit keeps the low 16 address bits, that the A20 flag tracks the stored byte, and that a write reads back masked on the next cycle. Only the bench's sweep can show the full picture. It writes all 256 byte values and probes pages on either side of each window, aliases above bit 20, both edge offsets and both SMM states. That sweep shows that each of the four pairings lands on the right DRAM page and that bits 7 and 0 leave the decode alone.

// File: rtl/smram_pkg.sv
package smram_pkg;
  localparam int OFS_W = 16;              // 64 KB window
  localparam logic [7:0] CFG_MASK = 8'hBE;
  localparam logic [7:0] DECODE_BITS = 8'h3E;
  localparam logic [15:0] HOST_PAGE_LO = 16'h0006;
  localparam logic [15:0] HOST_PAGE_HI = 16'h000E;
  localparam logic [15:0] RAM_PAGE_LO  = 16'h000A;
  localparam logic [15:0] RAM_PAGE_HI  = 16'h000B;

  typedef struct packed {
    logic reload;     // capture new window state this edge
    logic enable;
    logic anyMode;    // visible outside SMM too
    logic hostHi;     // host page select
    logic ramHi;      // DRAM page select
    logic a20;
  } winStrobe_t;
endpackage

// File: rtl/smram_cfg_ctrl.sv
module smram_cfg_ctrl
  import smram_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic [7:0] cfgWdata,
  output logic [7:0] cfgRdata,
  output winStrobe_t strobe
);
  logic [7:0] cfgReg;
  logic [7:0] maskedData;

  assign maskedData = cfgWdata & CFG_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) cfgReg <= '0;
    else if (cfgWe) cfgReg <= maskedData;
  end

  assign cfgRdata = cfgReg;

  always_comb begin
    strobe.reload  = cfgWe && (((maskedData ^ cfgReg) & DECODE_BITS) != 8'h00);
    strobe.enable  = maskedData[1];
    strobe.anyMode = maskedData[2];
    strobe.ramHi   = maskedData[3];
    strobe.hostHi  = maskedData[4];
    strobe.a20     = maskedData[5];
  end

  p_readback_mask_r1: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (cfgRdata == ($past(cfgWdata) & 8'hBE)));
  p_dead_bits_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdata[6] == 1'b0) && (cfgRdata[0] == 1'b0));
endmodule

// File: rtl/smram_remap_dp.sv
module smram_remap_dp
  import smram_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobe_t        strobe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              smmActive,
  output logic              hit,
  output logic [ADDR_W-1:0] dramAddr,
  output logic              a20Unmask
);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic winEn, winAny, winHostHi, winRamHi, winA20;
  logic [PAGE_W-1:0] hostPage, ramPage;
  logic pageMatch, modeOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winEn <= 1'b0; winAny <= 1'b0; winHostHi <= 1'b0;
      winRamHi <= 1'b0; winA20 <= 1'b0;
    end else if (strobe.reload) begin
      winEn     <= strobe.enable;
      winAny    <= strobe.anyMode;
      winHostHi <= strobe.hostHi;
      winRamHi  <= strobe.ramHi;
      winA20    <= strobe.a20;
    end
  end

  assign hostPage  = winHostHi ? PAGE_W'(HOST_PAGE_HI) : PAGE_W'(HOST_PAGE_LO);
  assign ramPage   = winRamHi  ? PAGE_W'(RAM_PAGE_HI)  : PAGE_W'(RAM_PAGE_LO);
  assign pageMatch = (hostAddr[ADDR_W-1:OFS_W] == hostPage);
  assign modeOk    = winAny || smmActive;
  assign hit       = winEn && modeOk && pageMatch;
  assign dramAddr  = hit ? {ramPage, hostAddr[OFS_W-1:0]} : hostAddr;
  assign a20Unmask = winA20;

  p_offset_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (dramAddr[OFS_W-1:0] == hostAddr[OFS_W-1:0]));
  p_legal_page_r7: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> ((hostAddr[ADDR_W-1:OFS_W] == PAGE_W'(HOST_PAGE_LO)) ||
             (hostAddr[ADDR_W-1:OFS_W] == PAGE_W'(HOST_PAGE_HI))));
endmodule

// File: rtl/smram_remap_decoder.sv
module smram_remap_decoder
  import smram_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              smmActive,
  output logic              hit,
  output logic [ADDR_W-1:0] dramAddr,
  output logic              a20Unmask
);
  winStrobe_t strobe;

  smram_cfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .strobe(strobe)
  );

  smram_remap_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostAddr(hostAddr),
    .smmActive(smmActive), .hit(hit), .dramAddr(dramAddr), .a20Unmask(a20Unmask)
  );

  p_disabled_no_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdata[1] |-> !hit);
  p_smm_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdata[1] && !cfgRdata[2] && !smmActive) |-> !hit);
  p_a20_follows_r5: assert property (@(posedge clk) disable iff (!rstN)
    a20Unmask == cfgRdata[5]);
endmodule

// File: tb/tb_smram_remap_decoder.sv
module tb_smram_remap_decoder;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [7:0] cfgWdata = '0;
  logic [7:0] cfgRdata;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic smmActive = 1'b0;
  logic hit, a20Unmask;
  logic [ADDR_W-1:0] dramAddr;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  smram_remap_decoder #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .hostAddr(hostAddr), .smmActive(smmActive),
    .hit(hit), .dramAddr(dramAddr), .a20Unmask(a20Unmask)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [7:0] v);
    @(negedge clk);
    cfgWe = 1'b1; cfgWdata = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Probe one address under a given stored byte and SMM state.
  task automatic probe(input logic [7:0] stored, input logic [ADDR_W-1:0] a, input logic smm);
    logic expHit;
    logic [ADDR_W-1:0] expAddr;
    logic [15:0] hp, rp;
    hostAddr = a; smmActive = smm;
    #1;
    hp = stored[4] ? 16'h000E : 16'h0006;          // R3 host page
    rp = stored[3] ? 16'h000B : 16'h000A;          // R3 DRAM page
    expHit = stored[1] && (stored[2] || smm) && (a[31:16] == hp);  // R2 R4 R7
    expAddr = expHit ? {rp, a[15:0]} : a;          // R6
    check("R2/R3/R4/R7 hit", 64'(hit), 64'(expHit));
    check("R3/R6 dramAddr", 64'(dramAddr), 64'(expAddr));
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          nFails++; nChecks++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8 cfgRdata", 64'(cfgRdata), 64'h00);
    check("R8 a20Unmask", 64'(a20Unmask), 64'h0);
    hostAddr = 32'h0006_1234; smmActive = 1'b1; #1;
    check("R8 hit", 64'(hit), 64'h0);

    for (int v = 0; v < 256; v++) begin
      logic [7:0] stored;
      stored = 8'(v) & 8'hBE;
      writeCfg(8'(v));
      check("R1 readback", 64'(cfgRdata), 64'(stored));
      check("R5 a20Unmask", 64'(a20Unmask), 64'(stored[5]));
      for (int p = 0; p < 8; p++) begin
        logic [15:0] pg;
        case (p)
          0: pg = 16'h0006; 1: pg = 16'h000E; 2: pg = 16'h0005;
          3: pg = 16'h0007; 4: pg = 16'h000A; 5: pg = 16'h0016;
          6: pg = 16'h1006; default: pg = 16'h800E;
        endcase
        for (int o = 0; o < 3; o++) begin
          logic [15:0] ofs;
          ofs = (o == 0) ? 16'h0000 : (o == 1) ? 16'hFFFF : 16'h5A3C;
          for (int s = 0; s < 2; s++)
            probe(stored, {pg, ofs}, s[0]);
        end
      end
    end

    // R9: bits 7 and 0 alone leave decode unchanged
    writeCfg(8'h06);
    hostAddr = 32'h0006_0042; smmActive = 1'b0; #1;
    check("R9 baseline hit", 64'(hit), 64'h1);
    writeCfg(8'h87);
    hostAddr = 32'h0006_0042; smmActive = 1'b0; #1;
    check("R9 hit after bit7/bit0 write", 64'(hit), 64'h1);
    check("R9 dramAddr after bit7/bit0 write", 64'(dramAddr), 64'h000A_0042);
    check("R9 a20 after bit7/bit0 write", 64'(a20Unmask), 64'h0);
    // R9: effect only from the cycle after the write edge
    @(negedge clk);
    cfgWe = 1'b1; cfgWdata = 8'h00;
    #1;
    check("R9 decode before edge", 64'(hit), 64'h1);
    @(negedge clk);
    cfgWe = 1'b0; #1;
    check("R9 decode after edge", 64'(hit), 64'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule